// File: doc/BRIEF.md
# Reconfigurable Digit Serial-Serial Multiplier

This block multiplies unsigned operands that arrive one digit at a time, least significant digit first, on both inputs at once. It returns the product one digit at a time, also least significant first. The datapath is built from `M` slices of `N` bits each. A split select, read when an operation starts, sets how the slices are grouped. All slices can join into one lane that multiplies `M*N`-bit operands. They can instead form 2, 4, … up to `M` independent lanes, each of width `w = M*N / lanes`. The lanes work concurrently, and each takes its own digit stream under its own valid strobe.

Each slice has an update enable that stands in for a gated clock. A slice belonging to a lane that the current operation does not use keeps every register frozen. A slice in a working lane updates only when its lane has a digit pair to absorb, or while that lane is flushing the upper half of its product. Each cycle a lane folds the cross terms of the new digit pair into a running sum. It then emits the lowest digit that can no longer change and shifts the sum down by one digit.

Top module: `rdsm_top`

## Requirements
- R1: With `split_sel = 0`, lane 0 alone forms the full `2*M*N`-bit product of two `M*N`-bit operands fed as `M*N/D` digit pairs on `a_dig[D-1:0]` / `b_dig[D-1:0]`. The product digits appear on `out_dig[D-1:0]`, least significant first.
- R2: With `split_sel = s`, there are `2^s` lanes. Lane `q` takes its digits on bits `[q*D +: D]` of `a_dig`/`b_dig`, qualified by `in_vld[q]`, and returns its `2w`-bit product on `out_dig[q*D +: D]`. Lanes do not affect one another, even when they run out of step.
- R3: A lane absorbs a digit pair only in cycles where its `in_vld` bit is high. Idle cycles inserted between digits do not change the product.
- R4: A lane raises `out_vld` for exactly `2w/D` cycles per operation. After its final input digit, it emits the remaining `w/D` digits on consecutive cycles without needing any input.
- R5: Outputs are registered. The product digit produced by an absorbed digit pair appears on the cycle after that pair was presented.
- R6: `done[q]` pulses for one cycle, on the cycle after the one carrying the lane's final product digit. `out_vld[q]` is low in that cycle.
- R7: `split_sel` and `lane_en` are read only in a cycle where `start` is high and `busy` is low. A `start` while `busy` is high is ignored. Digits are absorbed from the cycle after an accepted start.
- R8: A lane that is not enabled, or that lies beyond the lane count of the mode, never raises `out_vld`, and its `out_dig` field holds its value. The slices of that lane keep all registers unchanged.
- R9: After reset, `out_vld`, `done` and `busy` are all low.
- R10: All-ones operands of width `w` return `(2^w-1)^2` within the lane, with no carry into a neighbouring lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; samples split_sel and lane_en when idle |
| split_sel | input | LW | log2 of the lane count; values above log2(M) act as log2(M) |
| lane_en | input | M | Per-lane participation mask, read at start |
| in_vld | input | M | Per-lane digit valid |
| a_dig | input | M*D | Per-lane digit of operand A |
| b_dig | input | M*D | Per-lane digit of operand B |
| out_vld | output | M | Per-lane product digit valid |
| out_dig | output | M*D | Per-lane product digit |
| done | output | M | Per-lane completion pulse |
| busy | output | 1 | Some lane is loading or flushing |

## Verification
Random wide operands exercise the carry between slices inside one lane. All-ones operands push every partial sum to its maximum, so an accumulator too narrow or a carry leaking across a lane edge shows up. Split runs with one lane streaming steadily and the other stalled by valid gaps confirm that lane timing and results are independent. Runs with a lane disabled, or with a start pulse arriving mid-operation, show whether an unused lane's output stays frozen and whether the mode is held.

// File: rtl/rdsm_pkg.sv
package rdsm_pkg;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_LOAD  = 2'd1,
        LN_FLUSH = 2'd2
    } lane_st_e;

endpackage

// File: rtl/rdsm_lane.sv
module rdsm_lane
    import rdsm_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          vld,
    input  logic [CW-1:0] nd,
    output logic          consume,
    output logic          flush,
    output logic          last,
    output logic          busy,
    output logic [CW-1:0] k
);

    typedef struct packed {
        lane_st_e      st;
        logic [CW-1:0] cnt;
    } ln_t;

    ln_t ln_q, ln_d;
    logic at_end;

    always_comb begin
        ln_d   = ln_q;
        at_end = (ln_q.cnt == nd - CW'(1));
        unique case (ln_q.st)
            LN_IDLE: begin
                if (go) begin
                    ln_d.st  = LN_LOAD;
                    ln_d.cnt = '0;
                end
            end
            LN_LOAD: begin
                if (vld) begin
                    if (at_end) begin
                        ln_d.st  = LN_FLUSH;
                        ln_d.cnt = '0;
                    end else begin
                        ln_d.cnt = ln_q.cnt + CW'(1);
                    end
                end
            end
            LN_FLUSH: begin
                if (at_end) begin
                    ln_d.st  = LN_IDLE;
                    ln_d.cnt = '0;
                end else begin
                    ln_d.cnt = ln_q.cnt + CW'(1);
                end
            end
            default: ln_d = '{st: LN_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '{st: LN_IDLE, cnt: '0};
        else        ln_q <= ln_d;
    end

    assign consume = (ln_q.st == LN_LOAD) && vld;
    assign flush   = (ln_q.st == LN_FLUSH);
    assign last    = flush && at_end;
    assign busy    = (ln_q.st != LN_IDLE);
    assign k       = ln_q.cnt;

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_q.st == LN_LOAD && !vld) |=> (ln_q.st == LN_LOAD && $stable(ln_q.cnt)));

    // R4
    flush_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !last) |=> flush);

endmodule

// File: rtl/rdsm_slice.sv
module rdsm_slice #(
    parameter int N  = 32,
    parameter int D  = 4,
    parameter int KW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             ld,
    input  logic [KW-1:0]    ld_pos,
    input  logic [D-1:0]     a_dig,
    input  logic [D-1:0]     b_dig,
    input  logic [2*N-1:0]   acc_nx,
    output logic [N+D:0]     pp,
    output logic [2*N-1:0]   acc
);

    localparam int PW = N + D + 1;

    typedef struct packed {
        logic [N-1:0]   a;
        logic [N-1:0]   b;
        logic [2*N-1:0] acc;
    } sl_t;

    sl_t sl_q, sl_d;
    logic [N-1:0] b_upd;

    always_comb begin
        b_upd = sl_q.b;
        if (ld) b_upd[int'(ld_pos)*D +: D] = b_dig;

        pp = ({{(PW-D){1'b0}}, a_dig} * {{(PW-N){1'b0}}, b_upd})
           + ({{(PW-D){1'b0}}, b_dig} * {{(PW-N){1'b0}}, sl_q.a});

        sl_d = sl_q;
        if (clr) begin
            sl_d = '0;
        end else if (step) begin
            if (ld) begin
                sl_d.a[int'(ld_pos)*D +: D] = a_dig;
                sl_d.b = b_upd;
            end
            sl_d.acc = acc_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign acc = sl_q.acc;

endmodule

// File: rtl/rdsm_top.sv
module rdsm_top #(
    parameter int M = 2,
    parameter int N = 32,
    parameter int D = 4,
    localparam int LOG2M = (M > 1) ? $clog2(M) : 0,
    localparam int LW    = (LOG2M > 0) ? $clog2(LOG2M + 1) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LW-1:0]   split_sel,
    input  logic [M-1:0]    lane_en,
    input  logic [M-1:0]    in_vld,
    input  logic [M*D-1:0]  a_dig,
    input  logic [M*D-1:0]  b_dig,
    output logic [M-1:0]    out_vld,
    output logic [M*D-1:0]  out_dig,
    output logic [M-1:0]    done,
    output logic            busy
);

    localparam int DPS = N / D;
    localparam int KW  = (DPS > 1) ? $clog2(DPS) : 1;
    localparam int TOT = 2 * M * N / D;
    localparam int CW  = $clog2(TOT + 1);
    localparam int SW  = 2 * N;
    localparam int PW  = N + D + 1;
    localparam int TW  = 2 * M * N;

    typedef struct packed {
        logic [LW-1:0]  lvl;
        logic [M-1:0]   vld;
        logic [M*D-1:0] dig;
        logic [M-1:0]   fin;
        logic [M-1:0]   done;
    } top_t;

    top_t r_q, r_d;

    logic [LW-1:0] lvl_now;
    logic          start_ok;
    int            grp_q, grp_n, sh_q, sh_n;
    logic [CW-1:0] nd;

    logic [M-1:0]  ln_go, ln_cons, ln_flush, ln_last, ln_busy;
    logic [CW-1:0] ln_k [M];

    logic [M-1:0]  s_clr, s_step, s_ld;
    logic [KW-1:0] s_pos [M];
    logic [D-1:0]  s_a [M];
    logic [D-1:0]  s_b [M];
    logic [PW-1:0] s_pp [M];
    logic [SW-1:0] s_acc [M];
    logic [SW-1:0] s_sum [M];
    logic [SW-1:0] s_nx [M];
    logic [TW-1:0] pp_vec;

    // Mode selection: clip out-of-range split values to the finest split.
    always_comb begin
        lvl_now  = (int'(split_sel) > LOG2M) ? LW'(LOG2M) : split_sel;
        start_ok = start && !busy;
        sh_q     = LOG2M - int'(r_q.lvl);
        sh_n     = LOG2M - int'(lvl_now);
        grp_q    = M >> int'(r_q.lvl);
        grp_n    = M >> int'(lvl_now);
        nd       = CW'(grp_q * DPS);
        for (int q = 0; q < M; q++)
            ln_go[q] = start_ok && lane_en[q] && (q < (1 << int'(lvl_now)));
    end

    generate
        for (genvar gq = 0; gq < M; gq++) begin : g_lane
            rdsm_lane #(.CW(CW)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .go      (ln_go[gq]),
                .vld     (in_vld[gq]),
                .nd      (nd),
                .consume (ln_cons[gq]),
                .flush   (ln_flush[gq]),
                .last    (ln_last[gq]),
                .busy    (ln_busy[gq]),
                .k       (ln_k[gq])
            );
        end
    endgenerate

    // Route each lane's digits and enables to the slices of its group.
    always_comb begin
        int q, qn, i;
        for (int j = 0; j < M; j++) begin
            q  = j >> sh_q;
            qn = j >> sh_n;
            i  = j & (grp_q - 1);
            s_clr[j]  = ln_go[qn];
            s_step[j] = ln_cons[q] | ln_flush[q];
            s_ld[j]   = ln_cons[q] && ((int'(ln_k[q]) / DPS) == i);
            s_pos[j]  = KW'(int'(ln_k[q]) % DPS);
            s_a[j]    = ln_cons[q] ? a_dig[q*D +: D] : '0;
            s_b[j]    = ln_cons[q] ? b_dig[q*D +: D] : '0;
        end
    end

    generate
        for (genvar gj = 0; gj < M; gj++) begin : g_slice
            rdsm_slice #(.N(N), .D(D), .KW(KW)) u_slice (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (s_clr[gj]),
                .step   (s_step[gj]),
                .ld     (s_ld[gj]),
                .ld_pos (s_pos[gj]),
                .a_dig  (s_a[gj]),
                .b_dig  (s_b[gj]),
                .acc_nx (s_nx[gj]),
                .pp     (s_pp[gj]),
                .acc    (s_acc[gj])
            );
        end
    endgenerate

    // Place partial products, add with carries cut at lane edges, shift one digit.
    always_comb begin
        int q, i, nj;
        logic carry, cin;
        logic [D-1:0] hi;
        pp_vec = '0;
        for (int j = 0; j < M; j++) begin
            q = j >> sh_q;
            pp_vec = pp_vec + (TW'(s_pp[j]) << ((j + q * grp_q) * N));
        end
        carry = 1'b0;
        for (int j = 0; j < M; j++) begin
            i   = j & (grp_q - 1);
            cin = (i == 0) ? 1'b0 : carry;
            {carry, s_sum[j]} = {1'b0, s_acc[j]} + {1'b0, pp_vec[j*SW +: SW]}
                              + (SW+1)'(cin);
        end
        for (int j = 0; j < M; j++) begin
            i  = j & (grp_q - 1);
            nj = (j + 1 < M) ? j + 1 : j;
            hi = ((i + 1 < grp_q) && (j + 1 < M)) ? s_sum[nj][D-1:0] : '0;
            s_nx[j] = {hi, s_sum[j][SW-1:D]};
        end
    end

    always_comb begin
        int fs;
        r_d = r_q;
        if (start_ok) r_d.lvl = lvl_now;
        for (int q = 0; q < M; q++) begin
            fs = (q * grp_q < M) ? q * grp_q : 0;
            r_d.vld[q] = ln_cons[q] | ln_flush[q];
            if (ln_cons[q] | ln_flush[q]) r_d.dig[q*D +: D] = s_sum[fs][D-1:0];
            r_d.fin[q]  = ln_last[q];
            r_d.done[q] = r_q.fin[q];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_vld = r_q.vld;
    assign out_dig = r_q.dig;
    assign done    = r_q.done;
    assign busy    = |ln_busy;

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(r_q.lvl));

    generate
        for (genvar aq = 0; aq < M; aq++) begin : g_lane_chk
            // R6
            done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
                done[aq] |-> ($past(out_vld[aq]) && !out_vld[aq]));
            // R8
            vld_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld[aq] |-> $past(ln_busy[aq]));
        end
        for (genvar aj = 0; aj < M; aj++) begin : g_slice_chk
            // R8
            idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy && !start) |=> $stable(s_acc[aj]));
        end
    endgenerate

endmodule

// File: tb/sim_rdsm_top.sv
module sim_rdsm_top;

    localparam int CLK_NS = 10;
    localparam int M = 2;
    localparam int N = 32;
    localparam int D = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [0:0]     split_sel = '0;
    logic [M-1:0]   lane_en = '0;
    logic [M-1:0]   in_vld = '0;
    logic [M*D-1:0] a_dig = '0;
    logic [M*D-1:0] b_dig = '0;
    logic [M-1:0]   out_vld;
    logic [M*D-1:0] out_dig;
    logic [M-1:0]   done;
    logic           busy;

    int cyc = 0;
    int vectors = 0;
    int miscomp = 0;
    int live = 0;

    rdsm_top #(.M(M), .N(N), .D(D)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .split_sel(split_sel),
        .lane_en(lane_en), .in_vld(in_vld), .a_dig(a_dig), .b_dig(b_dig),
        .out_vld(out_vld), .out_dig(out_dig), .done(done), .busy(busy)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic collect(input int q, input bit act, input int ndig,
                           output logic [127:0] got, output int nd,
                           output int first, output int last,
                           output bit done_ok, output bit held);
        logic [D-1:0] ref_dig;
        got = '0; nd = 0; first = -1; last = -1; done_ok = 1'b0; held = 1'b1;
        ref_dig = out_dig[q*D +: D];
        if (!act) begin
            for (int t = 0; t < 600 && live > 0; t++) begin
                @(negedge clk);
                if (out_vld[q] || out_dig[q*D +: D] != ref_dig) held = 1'b0;
            end
        end else begin
            for (int t = 0; t < 600 && nd < ndig; t++) begin
                @(negedge clk);
                if (out_vld[q]) begin
                    if (nd == 0) first = cyc;
                    got[nd*D +: D] = out_dig[q*D +: D];
                    nd++;
                    last = cyc;
                end
            end
            @(negedge clk);
            done_ok = done[q] && !out_vld[q];
            @(negedge clk);
            done_ok = done_ok && !done[q];
            live--;
        end
    endtask

    task automatic run_op(input string req, input logic sel, input logic [1:0] en,
                          input logic [63:0] a0, input logic [63:0] b0,
                          input logic [63:0] a1, input logic [63:0] b1,
                          input bit gap0, input bit gap1, input bit bump);
        int w = sel ? 32 : 64;
        int nd = w / D;
        bit act [M];
        logic [63:0] opa [M];
        logic [63:0] opb [M];
        bit gap [M];
        int fd [M];
        logic [127:0] got [M];
        int cnt [M], fst [M], lst [M];
        bit dok [M], hld [M];
        logic [127:0] exp;
        bit busy_seen = 1'b1;

        opa[0] = a0; opb[0] = b0; opa[1] = a1; opb[1] = b1;
        gap[0] = gap0; gap[1] = gap1;
        live = 0;
        for (int q = 0; q < M; q++) begin
            act[q] = en[q] && (q < (sel ? 2 : 1));
            fd[q] = -1;
            if (act[q]) live++;
        end

        @(negedge clk);
        start = 1'b1; split_sel = sel; lane_en = en;
        @(negedge clk);
        start = 1'b0;

        fork
            begin : feeder
                int idx [M];
                bit v;
                idx[0] = 0; idx[1] = 0;
                for (int it = 0; (act[0] && idx[0] < nd) || (act[1] && idx[1] < nd); it++) begin
                    start = bump && (it == 2);
                    if (bump && it == 2) begin
                        split_sel = 1'b1; lane_en = 2'b11;
                        busy_seen = busy;
                    end
                    for (int q = 0; q < M; q++) begin
                        if (act[q] && idx[q] < nd) begin
                            v = gap[q] ? ((it % 3) != 1) : 1'b1;
                            in_vld[q] = v;
                            a_dig[q*D +: D] = opa[q][idx[q]*D +: D];
                            b_dig[q*D +: D] = opb[q][idx[q]*D +: D];
                            if (v) begin
                                if (fd[q] < 0) fd[q] = cyc;
                                idx[q]++;
                            end
                        end else begin
                            in_vld[q] = 1'b0;
                            a_dig[q*D +: D] = 4'hF;
                            b_dig[q*D +: D] = 4'hF;
                        end
                    end
                    @(negedge clk);
                end
                in_vld = '0; start = 1'b0;
            end
            collect(0, act[0], 2*nd, got[0], cnt[0], fst[0], lst[0], dok[0], hld[0]);
            collect(1, act[1], 2*nd, got[1], cnt[1], fst[1], lst[1], dok[1], hld[1]);
        join

        if (bump) chk(busy_seen, "R7 busy during ignored start", 128'(busy_seen), 128'd1);
        for (int q = 0; q < M; q++) begin
            if (act[q]) begin
                if (sel) exp = 128'({64'd0, opa[q][31:0]} * {64'd0, opb[q][31:0]});
                else     exp = 128'({64'd0, opa[q]} * {64'd0, opb[q]});
                chk(got[q] == exp, $sformatf("%s product lane %0d", req, q), got[q], exp);
                chk(cnt[q] == 2*nd, "R4 digit count", 128'(cnt[q]), 128'(2*nd));
                if (!gap[q]) begin
                    chk(fst[q] - fd[q] == 1, "R5 first digit latency",
                        128'(fst[q] - fd[q]), 128'd1);
                    chk(lst[q] - fst[q] == 2*nd - 1, "R4 contiguous output",
                        128'(lst[q] - fst[q]), 128'(2*nd - 1));
                end
                chk(dok[q], "R6 done pulse", 128'(dok[q]), 128'd1);
            end else begin
                chk(hld[q], $sformatf("R8 idle lane %0d held", q), 128'(hld[q]), 128'd1);
            end
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_vld == '0, "R9 out_vld after reset", 128'(out_vld), 128'd0);
        chk(done == '0, "R9 done after reset", 128'(done), 128'd0);
        chk(busy == 1'b0, "R9 busy after reset", 128'(busy), 128'd0);
    endtask

    task automatic t_wide_random;
        run_op("R1", 1'b0, 2'b01, {$urandom, $urandom}, {$urandom, $urandom}, 64'd0, 64'd0, 0, 0, 0);
        run_op("R1", 1'b0, 2'b01, 64'h8000_0000_0000_0001, 64'hFFFF_0000_1234_5678, 64'd0, 64'd0, 0, 0, 0);
    endtask

    task automatic t_wide_ones;
        run_op("R10 wide", 1'b0, 2'b01, '1, '1, 64'd0, 64'd0, 0, 0, 0);
    endtask

    task automatic t_wide_gaps;
        run_op("R3 wide gaps", 1'b0, 2'b01, {$urandom, $urandom}, {$urandom, $urandom}, 64'd0, 64'd0, 1, 0, 0);
    endtask

    task automatic t_split_pair;
        run_op("R2 R3 split", 1'b1, 2'b11, {32'd0, $urandom}, {32'd0, $urandom},
               {32'd0, $urandom}, {32'd0, $urandom}, 0, 1, 0);
    endtask

    task automatic t_split_ones;
        run_op("R10 split", 1'b1, 2'b11, 64'hFFFF_FFFF, 64'hFFFF_FFFF,
               64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 0, 0);
    endtask

    task automatic t_split_one_lane;
        run_op("R2 R8 lane0 only", 1'b1, 2'b01, {32'd0, $urandom}, {32'd0, $urandom},
               64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 0, 0);
        run_op("R2 R8 lane1 only", 1'b1, 2'b10, 64'hFFFF_FFFF, 64'hFFFF_FFFF,
               {32'd0, $urandom}, {32'd0, $urandom}, 0, 0, 0);
    endtask

    task automatic t_start_while_busy;
        run_op("R7 R1 start ignored", 1'b0, 2'b01, {$urandom, $urandom}, {$urandom, $urandom},
               64'd0, 64'd0, 0, 0, 1);
    endtask

    initial begin
        #(CLK_NS * 150000);
        vectors++;
        miscomp++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide_random();
        t_wide_ones();
        t_wide_gaps();
        t_split_pair();
        t_split_ones();
        t_split_one_lane();
        t_start_while_busy();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule